// File: doc/BRIEF.md
# Filtered Message Trace Recorder

The recorder observes a message stream in which every message carries a 12-bit source identifier, a 12-bit destination identifier and a data payload. It selects the messages that pass the configured filters. It writes each selected message as one record into a trace window in memory. The window runs from a programmed first slot to a programmed last slot. The block presents these records on a plain write port made of valid, address and data. The protocol that carries the writes to real memory belongs to the surrounding logic.

Software sets up the block through one 40-bit control word and two slot addresses. The control word turns tracing on. It can also turn on a destination-identifier filter, a source-identifier filter, or both. A wrap bit sets what happens when the window is used up. With wrap set, recording continues from the first slot again. With wrap clear, recording halts and a sticky full flag is raised. The block takes at most one message per cycle and applies no backpressure, so every selected message is either written or, once the window is full in stop mode, dropped.

Top module: `trc_recorder`

## Requirements
- R1: After reset, wr_valid and trace_full are both 0.
- R2: While control bit 0 (enable) is 0, no record is written, whatever the message inputs are.
- R3: When control bit 39 (destination filter on) is 1, a message is recorded only if msg_dst equals control bits 35:24.
- R4: When control bit 23 (source filter on) is 1, a message is recorded only if msg_src equals control bits 19:8.
- R5: When both filters are on, a message needs both matches to be recorded. When both are off, every valid message is recorded while enabled.
- R6: Each recorded message shows up on the write port exactly one cycle after it is presented. wr_data equals msg_data. Successive records take successive addresses, starting at cfg_base.
- R7: With control bit 1 (wrap) at 1, the record after the one written at cfg_limit goes to cfg_base, and trace_full stays 0.
- R8: With wrap at 0, the record written at cfg_limit is the last one. trace_full becomes 1 in the same cycle that this write appears, and later messages are dropped.
- R9: A 0-to-1 change of the enable bit clears trace_full and returns the write position to cfg_base. A message that qualifies in that same cycle is written at cfg_base.
- R10: Qualifying messages on consecutive cycles produce writes on consecutive cycles, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ctrl | input | 40 | Control word: enable, wrap, filter enables and identifiers |
| cfg_base | input | ADDR_W | First slot of the trace window |
| cfg_limit | input | ADDR_W | Last slot of the trace window (not below cfg_base) |
| msg_valid | input | 1 | A message is present this cycle |
| msg_src | input | 12 | Source identifier of the message |
| msg_dst | input | 12 | Destination identifier of the message |
| msg_data | input | DATA_W | Message payload |
| wr_valid | output | 1 | A record write is issued |
| wr_addr | output | ADDR_W | Slot address of the record |
| wr_data | output | DATA_W | Record payload |
| trace_full | output | 1 | Sticky: the window filled while in stop mode |

## Verification
Two functions can coincide in a single cycle. The first is re-arming through an enable rising edge. The second is recording a message. The bench takes enable low for one cycle, then raises it in the same cycle that it presents a qualifying message to a full window. The test passes if that message is written at cfg_base and trace_full reads 0 at the same sampling point. A second coincidence is the write to the last slot together with the full flag rising. The bench checks both at the same sample after the fourth message into a four-slot window.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int ID_W   = 12;
    localparam int CTRL_W = 40;

    // Decoded view of the control word; bit positions fixed by software
    typedef struct packed {
        logic            dst_on;
        logic [ID_W-1:0] dst_id;
        logic            src_on;
        logic [ID_W-1:0] src_id;
        logic            wrap;
        logic            en;
    } trc_ctrl_t;

    function automatic trc_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
        trc_ctrl_t c;
        c.dst_on = w[39];
        c.dst_id = w[35:24];
        c.src_on = w[23];
        c.src_id = w[19:8];
        c.wrap   = w[1];
        c.en     = w[0];
        return c;
    endfunction

    // Identifier filter: passes when disabled, else needs equality
    function automatic logic id_pass(input logic on, input logic [ID_W-1:0] want,
                                     input logic [ID_W-1:0] got);
        return !on || (want == got);
    endfunction

endpackage

// File: rtl/trc_filter.sv
module trc_filter
    import trc_pkg::*;
(
    input  trc_ctrl_t       ctrl,
    input  logic            msg_valid,
    input  logic [ID_W-1:0] msg_src,
    input  logic [ID_W-1:0] msg_dst,
    output logic            hit
);

    logic dst_ok;
    logic src_ok;

    always_comb begin
        dst_ok = id_pass(ctrl.dst_on, ctrl.dst_id, msg_dst);
        src_ok = id_pass(ctrl.src_on, ctrl.src_id, msg_src);
        hit    = msg_valid && ctrl.en && dst_ok && src_ok;
    end

endmodule

// File: rtl/trc_addr_seq.sv
module trc_addr_seq #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              hit,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic              accept,
    output logic [ADDR_W-1:0] slot_addr,
    output logic              full_q
);

    logic [ADDR_W-1:0] ptr_q;
    logic              eff_full;
    logic              at_limit;

    always_comb begin
        slot_addr = arm ? base : ptr_q;
        eff_full  = arm ? 1'b0 : full_q;
        accept    = hit && !eff_full;
        at_limit  = (slot_addr == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            full_q <= 1'b0;
        end else if (accept) begin
            full_q <= 1'b0;
            if (at_limit) begin
                if (wrap) begin
                    ptr_q <= base;
                end else begin
                    ptr_q  <= slot_addr;
                    full_q <= 1'b1;
                end
            end else begin
                ptr_q <= slot_addr + 1'b1;
            end
        end else if (arm) begin
            ptr_q  <= base;
            full_q <= 1'b0;
        end
    end

    assert_step_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && !at_limit) |=> (ptr_q == ADDR_W'($past(slot_addr) + 1'b1)));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && at_limit && wrap) |=> (ptr_q == $past(base) && !full_q));

    assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && at_limit && !wrap) |=> full_q);

    assert_rearm_R9: assert property (@(posedge clk) disable iff (rst)
        (arm && !accept) |=> (ptr_q == $past(base) && !full_q));

endmodule

// File: rtl/trc_recorder.sv
module trc_recorder
    import trc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [39:0]       cfg_ctrl,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic              msg_valid,
    input  logic [11:0]       msg_src,
    input  logic [11:0]       msg_dst,
    input  logic [DATA_W-1:0] msg_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              trace_full
);

    trc_ctrl_t         ctrl;
    logic              en_q;
    logic              arm;
    logic              hit;
    logic              accept;
    logic [ADDR_W-1:0] slot_addr;

    always_comb begin
        ctrl = decode_ctrl(cfg_ctrl);
        arm  = ctrl.en && !en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ctrl.en;
    end

    trc_filter u_filter (
        .ctrl      (ctrl),
        .msg_valid (msg_valid),
        .msg_src   (msg_src),
        .msg_dst   (msg_dst),
        .hit       (hit)
    );

    trc_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .hit       (hit),
        .wrap      (ctrl.wrap),
        .base      (cfg_base),
        .limit     (cfg_limit),
        .accept    (accept),
        .slot_addr (slot_addr),
        .full_q    (trace_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= accept;
            if (accept) begin
                wr_addr <= slot_addr;
                wr_data <= msg_data;
            end
        end
    end

    assert_off_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |=> !wr_valid);

    assert_dst_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && ctrl.dst_on) |-> (msg_dst == ctrl.dst_id));

    assert_src_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && ctrl.src_on) |-> (msg_src == ctrl.src_id));

    assert_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (trace_full && !arm) |=> !wr_valid);

    assert_fullwrite_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(trace_full) |-> wr_valid);

endmodule

// File: tb/trc_recorder_tb.sv
module trc_recorder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [39:0]   cfg_ctrl;
    logic [AW-1:0] cfg_base;
    logic [AW-1:0] cfg_limit;
    logic          msg_valid;
    logic [11:0]   msg_src;
    logic [11:0]   msg_dst;
    logic [DW-1:0] msg_data;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          trace_full;

    int total = 0;
    int bad   = 0;
    logic [AW-1:0] exp_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    trc_recorder #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .cfg_ctrl(cfg_ctrl), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .msg_valid(msg_valid), .msg_src(msg_src),
        .msg_dst(msg_dst), .msg_data(msg_data), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .trace_full(trace_full)
    );

    typedef struct packed {
        logic        dst_on;
        logic [11:0] dst_id;
        logic        src_on;
        logic [11:0] src_id;
        logic [11:0] m_src;
        logic [11:0] m_dst;
        logic        hit;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{1'b0, 12'h000, 1'b0, 12'h000, 12'h123, 12'h456, 1'b1}, // R5 no filter
        '{1'b1, 12'h456, 1'b0, 12'h000, 12'h001, 12'h456, 1'b1}, // R3 dst match
        '{1'b1, 12'h456, 1'b0, 12'h000, 12'h001, 12'h457, 1'b0}, // R3 dst miss
        '{1'b0, 12'h000, 1'b1, 12'hABC, 12'hABC, 12'h999, 1'b1}, // R4 src match
        '{1'b0, 12'h000, 1'b1, 12'hABC, 12'hABD, 12'h999, 1'b0}, // R4 src miss
        '{1'b1, 12'h010, 1'b1, 12'h020, 12'h020, 12'h010, 1'b1}, // R5 both
        '{1'b1, 12'h010, 1'b1, 12'h020, 12'h021, 12'h010, 1'b0}, // R5 src fails
        '{1'b1, 12'h010, 1'b1, 12'h020, 12'h020, 12'h011, 1'b0}, // R5 dst fails
        '{1'b1, 12'hFFF, 1'b0, 12'h000, 12'h000, 12'hFFF, 1'b1}, // R3 all ones
        '{1'b0, 12'h7FF, 1'b0, 12'h800, 12'hFFF, 12'h000, 1'b1}  // R5 ids ignored
    };

    function automatic logic [39:0] mk_ctrl(input logic dst_on, input logic [11:0] dst_id,
                                            input logic src_on, input logic [11:0] src_id,
                                            input logic wrap, input logic en);
        logic [39:0] w = '0;
        w[39] = dst_on; w[35:24] = dst_id; w[23] = src_on;
        w[19:8] = src_id; w[1] = wrap; w[0] = en;
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one message at a negedge, sample outputs at the next negedge
    task automatic send(input logic v, input logic [11:0] s, input logic [11:0] d,
                        input logic [DW-1:0] data);
        msg_valid = v; msg_src = s; msg_dst = d; msg_data = data;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic disable_one_cycle();
        cfg_ctrl[0] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_ctrl = '0; cfg_base = '0; cfg_limit = 16'hFFFF;
        msg_valid = 1'b0; msg_src = '0; msg_dst = '0; msg_data = '0;
        repeat (3) @(negedge clk);
        check("R1 wr_valid", 64'(wr_valid), 64'd0);
        check("R1 trace_full", 64'(trace_full), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2: disabled, message ignored
        send(1'b1, 12'h111, 12'h222, 32'hDEAD0001);
        check("R2 no write when disabled", 64'(wr_valid), 64'd0);

        // Table walk: wrap on, large window from base 0x100
        cfg_base = 16'h0100; cfg_limit = 16'h01FF;
        cfg_ctrl = mk_ctrl(1'b0, 12'h0, 1'b0, 12'h0, 1'b1, 1'b1);
        exp_addr = 16'h0100;
        for (int i = 0; i < 10; i++) begin
            cfg_ctrl = mk_ctrl(TBL[i].dst_on, TBL[i].dst_id, TBL[i].src_on,
                               TBL[i].src_id, 1'b1, 1'b1);
            send(1'b1, TBL[i].m_src, TBL[i].m_dst, 32'hA000_0000 + i);
            check("R3/R4/R5 filter", 64'(wr_valid), 64'(TBL[i].hit));
            if (TBL[i].hit) begin
                check("R6 addr", 64'(wr_addr), 64'(exp_addr));
                check("R6 data", 64'(wr_data), 64'(32'hA000_0000 + i));
                exp_addr++;
            end
        end

        // Stop mode: window of four slots, re-armed with the first message (R9)
        disable_one_cycle();
        cfg_base = 16'h0010; cfg_limit = 16'h0013;
        cfg_ctrl = mk_ctrl(1'b0, 12'h0, 1'b0, 12'h0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            send(1'b1, 12'h5, 12'h6, 32'hB000_0000 + i);
            check("R10 back-to-back", 64'(wr_valid), 64'd1);
            check("R6 seq addr", 64'(wr_addr), 64'(16'h0010 + i));
            check("R8 full timing", 64'(trace_full), (i == 3) ? 64'd1 : 64'd0);
        end
        send(1'b1, 12'h5, 12'h6, 32'hB000_0009);
        check("R8 dropped after full", 64'(wr_valid), 64'd0);
        check("R8 full sticky", 64'(trace_full), 64'd1);

        // R9: re-arm in the same cycle as a qualifying message
        disable_one_cycle();
        check("R8 full holds while disabled", 64'(trace_full), 64'd1);
        cfg_ctrl[0] = 1'b1;
        send(1'b1, 12'h5, 12'h6, 32'hC0DE_0001);
        check("R9 write on rearm", 64'(wr_valid), 64'd1);
        check("R9 addr at base", 64'(wr_addr), 64'h0010);
        check("R9 full cleared", 64'(trace_full), 64'd0);

        // R7: wrap mode, six messages into four slots
        disable_one_cycle();
        cfg_ctrl = mk_ctrl(1'b0, 12'h0, 1'b0, 12'h0, 1'b1, 1'b1);
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            send(1'b1, 12'h1, 12'h2, 32'hD000_0000 + i);
            check("R7 write", 64'(wr_valid), 64'd1);
            check("R7 wrap addr", 64'(wr_addr), 64'(16'h0010 + (i % 4)));
            check("R7 never full", 64'(trace_full), 64'd0);
        end

        // R2 again: enable dropped mid-stream
        cfg_ctrl[0] = 1'b0;
        send(1'b1, 12'h1, 12'h2, 32'hE000_0000);
        check("R2 disabled mid-stream", 64'(wr_valid), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule